// File: doc/BRIEF.md
# Ethernet PHY clock generator

This block makes the PHY reference clock and the transmit clock for an Ethernet MAC wrapper. One 32-bit control word holds all of its settings. Software writes that word through a plain write strobe and reads it back at any time. The word selects one of two fast sources, divides it in two cascaded stages, picks the interface mode and sets how the transmit clock is shaped.

The block runs on one system clock. Each fast source enters as a one-cycle tick strobe in that clock domain, and every count is a count of ticks from the selected source. The first stage divides by a one-based 3-bit value. The second stage divides its result by 5 or by 10. The transmit clock is a copy of the reference clock. In the wide-interface (RGMII) mode it can be delayed in quarter-period steps. In the reduced-interface (RMII) mode it can be inverted instead. Both clock outputs are registered.

Top module: `eth_phyclk_gen`

## Requirements
- R1: Synchronous reset clears the control word to 0, and both clock outputs read 0 after reset.
- R2: A cycle with `wr_en` high stores `wr_data`. `rd_data` shows the stored word from the next cycle on.
- R3: While bit 12 (generator enable) is clear, `phy_ref_clk` and `tx_clk` are 0 one cycle later, and the divider phase is held at 0.
- R4: Bit 4 selects the tick source: 0 counts `src0_tick` and 1 counts `src1_tick`. The unselected strobe has no effect on the outputs.
- R5: Bits 9:7 give the first-stage ratio N1 in one-based form: value v divides by v, and value 0 divides by 1.
- R6: Bit 10 sets the second-stage ratio N2: 0 divides by 5 and 1 divides by 10. The full period is T = N1*N2 ticks.
- R7: Within each period, `phy_ref_clk` is high for the first ceil(T/2) ticks and low for the rest. The output is registered one cycle after the phase state.
- R8: When bit 0 is set (RGMII), `tx_clk` equals the reference waveform delayed by floor(k*T/4) ticks, where k is bits 6:5 (0 none, 1 quarter, 2 half, 3 three quarters).
- R9: When bit 0 is clear (RMII), bits 6:5 have no effect. `tx_clk` equals `phy_ref_clk`, or its complement while bit 11 is set.
- R10: In RGMII mode, bit 11 has no effect on `tx_clk`.
- R11: A write that changes bit 4 or bits 10:7 restarts the divider phase at 0 on that edge.
- R12: `rgmii_mode` follows the stored bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Stored control word |
| src0_tick | input | 1 | Tick strobe of fast source 0 |
| src1_tick | input | 1 | Tick strobe of fast source 1 (optional; tie low if absent) |
| phy_ref_clk | output | 1 | Divided PHY reference clock |
| tx_clk | output | 1 | Delayed or inverted transmit clock |
| rgmii_mode | output | 1 | Interface mode, 1 for RGMII |

## Verification
If a divider counter slips, it moves the edges of `phy_ref_clk` within one period, at most T ticks, and the edge-by-edge comparison against a single-counter model catches it. A wrong delay offset or a wrong inversion shows on `tx_clk` in the first period after the setting is written. Phase restart on a change of divider or source shows in the very next cycle, so writes land at random phases to expose it.

// File: rtl/eth_phyclk_gen.sv
module eth_phyclk_gen #(
  parameter int CW = 32,
  parameter int DIV1_W = 3,
  parameter bit SRC1_PRESENT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] rd_data,
  input  logic          src0_tick,
  input  logic          src1_tick,
  output logic          phy_ref_clk,
  output logic          tx_clk,
  output logic          rgmii_mode
);
  localparam int B_MODE = 0;
  localparam int B_SEL  = 4;
  localparam int B_DLY  = 5;
  localparam int B_D1   = 7;
  localparam int B_S2   = B_D1 + DIV1_W;
  localparam int B_INV  = B_S2 + 1;
  localparam int B_EN   = B_S2 + 2;
  localparam int MAXT   = ((1 << DIV1_W) - 1) * 10;
  localparam int TW     = $clog2(MAXT + 1) + 1;

  logic [CW-1:0]     ctrl_q;
  logic [DIV1_W-1:0] c1_q;
  logic [3:0]        c2_q;
  logic              ref_q, tx_q;

  wire              en    = ctrl_q[B_EN];
  wire              rgmii = ctrl_q[B_MODE];
  wire              inv   = ctrl_q[B_INV];
  wire [DIV1_W-1:0] d1f   = ctrl_q[B_D1 +: DIV1_W];
  wire [1:0]        code  = ctrl_q[B_DLY +: 2];

  wire [TW-1:0] n1  = (d1f == '0) ? TW'(1) : TW'(d1f);
  wire [3:0]    n2  = ctrl_q[B_S2] ? 4'd10 : 4'd5;
  wire [TW-1:0] tot = TW'(n1 * TW'(n2));
  wire [TW-1:0] hi  = TW'((tot + TW'(1)) >> 1);

  wire [TW+1:0] prod = (TW+2)'(tot) * (TW+2)'(code);
  wire [TW-1:0] dly  = rgmii ? TW'(prod >> 2) : '0;

  wire tick = ctrl_q[B_SEL] ? (SRC1_PRESENT & src1_tick) : src0_tick;

  wire cfg_chg = wr_en &&
    ((wr_data[B_S2:B_D1] != ctrl_q[B_S2:B_D1]) || (wr_data[B_SEL] != ctrl_q[B_SEL]));
  wire restart = !en || cfg_chg;

  wire          c1_wrap = (TW'(c1_q) == n1 - TW'(1));
  wire          c2_wrap = (c2_q == n2 - 4'd1);
  wire [TW-1:0] ph      = TW'(TW'(c2_q) * n1 + TW'(c1_q));
  wire [TW:0]   psum    = {1'b0, ph} + {1'b0, tot} - {1'b0, dly};
  wire [TW-1:0] pd      = (psum >= {1'b0, tot}) ? TW'(psum - {1'b0, tot}) : TW'(psum);

  wire ref_lvl = (ph < hi);
  wire tx_lvl  = (pd < hi) ^ (!rgmii && inv);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      c1_q   <= '0;
      c2_q   <= '0;
      ref_q  <= 1'b0;
      tx_q   <= 1'b0;
    end else begin
      if (wr_en) ctrl_q <= wr_data;
      if (restart) begin
        c1_q <= '0;
        c2_q <= '0;
      end else if (tick) begin
        if (c1_wrap) begin
          c1_q <= '0;
          c2_q <= c2_wrap ? 4'd0 : c2_q + 4'd1;
        end else begin
          c1_q <= c1_q + DIV1_W'(1);
        end
      end
      ref_q <= en && ref_lvl;
      tx_q  <= en && tx_lvl;
    end
  end

  assign rd_data     = ctrl_q;
  assign phy_ref_clk = ref_q;
  assign tx_clk      = tx_q;
  assign rgmii_mode  = rgmii;

  // R3
  gate_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!phy_ref_clk && !tx_clk));

  // R5
  c1_range_chk: assert property (@(posedge clk) disable iff (rst)
    TW'(c1_q) < n1);

  // R6
  c2_range_chk: assert property (@(posedge clk) disable iff (rst)
    c2_q < n2);

  // R9
  rmii_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !rgmii && !inv) |=> (tx_clk == phy_ref_clk));

  // R9
  rmii_invert_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !rgmii && inv) |=> (tx_clk != phy_ref_clk));

  // R11
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_chg |=> (c1_q == '0 && c2_q == '0));
endmodule

// File: tb/tb_eth_phyclk_gen.sv
module tb_eth_phyclk_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        src0_tick = 1'b0;
  logic        src1_tick = 1'b0;
  logic [31:0] rd_data;
  logic        phy_ref_clk, tx_clk, rgmii_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit live   = 1'b0;
  string tag_ref = "R1";
  string tag_tx  = "R1";

  always #4 clk = ~clk;

  eth_phyclk_gen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .src0_tick(src0_tick), .src1_tick(src1_tick),
    .phy_ref_clk(phy_ref_clk), .tx_clk(tx_clk), .rgmii_mode(rgmii_mode)
  );

  function automatic int ratio(input logic [31:0] c);
    int n1 = (c[9:7] == 0) ? 1 : int'(c[9:7]);
    return n1 * (c[10] ? 10 : 5);
  endfunction

  function automatic bit ref_level(input logic [31:0] c, input int ph);
    return ph < (ratio(c) + 1) / 2;
  endfunction

  function automatic bit tx_level(input logic [31:0] c, input int ph);
    int t = ratio(c);
    int d = c[0] ? (int'(c[6:5]) * t) / 4 : 0;
    bit l = ((ph - d + t) % t) < (t + 1) / 2;
    return l ^ (!c[0] && c[11]);
  endfunction

  logic [31:0] m_ctrl = '0;
  int          m_ph   = 0;
  bit          e_ref  = 1'b0;
  bit          e_tx   = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl <= '0; m_ph <= 0; e_ref <= 1'b0; e_tx <= 1'b0;
    end else begin
      e_ref <= m_ctrl[12] && ref_level(m_ctrl, m_ph);
      e_tx  <= m_ctrl[12] && tx_level(m_ctrl, m_ph);
      if (!m_ctrl[12] || (wr_en && (wr_data[10:7] != m_ctrl[10:7] || wr_data[4] != m_ctrl[4])))
        m_ph <= 0;
      else if (m_ctrl[4] ? src1_tick : src0_tick)
        m_ph <= (m_ph + 1) % ratio(m_ctrl);
      if (wr_en) m_ctrl <= wr_data;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live && !rst) begin
      chk(tag_ref, 32'(phy_ref_clk), 32'(e_ref));
      chk(tag_tx, 32'(tx_clk), 32'(e_tx));
      chk("R2", rd_data, m_ctrl);
      chk("R12", 32'(rgmii_mode), 32'(m_ctrl[0]));
    end
  end

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n, input int p0, input int p1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      src0_tick = ($urandom % 100) < p0;
      src1_tick = ($urandom % 100) < p1;
    end
    @(negedge clk);
    src0_tick = 1'b0; src1_tick = 1'b0;
  endtask

  task automatic phase(input string t, input logic [31:0] v, input int n, input int p0, input int p1);
    tag_ref = t; tag_tx = t;
    wr(v);
    run(n, p0, p1);
  endtask

  localparam logic [31:0] EN = 32'h1000;

  initial begin
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", rd_data, 32'h0);
    chk("R1", 32'(phy_ref_clk), 32'h0);
    chk("R1", 32'(tx_clk), 32'h0);
    live = 1'b1;

    phase("R3", 32'h0000_0381, 80, 100, 100);
    phase("R5", EN | (32'd0 << 7), 60, 100, 0);
    phase("R5", EN | (32'd1 << 7), 60, 100, 0);
    phase("R5", EN | (32'd7 << 7), 150, 70, 0);
    phase("R6", EN | 32'h400 | (32'd3 << 7), 200, 100, 0);
    phase("R7", EN | (32'd3 << 7), 120, 100, 0);
    phase("R4", EN | 32'h10 | (32'd2 << 7), 200, 100, 60);
    phase("R4", EN | 32'h10 | (32'd2 << 7), 60, 100, 0);
    phase("R4", EN | (32'd2 << 7), 200, 50, 100);
    for (int k = 0; k < 4; k++)
      phase("R8", EN | 32'h1 | 32'h400 | (32'd2 << 7) | (32'(k) << 5), 200, 100, 0);
    phase("R8", EN | 32'h1 | (32'd3 << 7) | (32'd3 << 5), 150, 100, 0);
    phase("R10", EN | 32'h1 | 32'h800 | (32'd1 << 5), 120, 100, 0);
    phase("R9", EN | (32'd3 << 5), 120, 100, 0);
    phase("R9", EN | 32'h800 | (32'd2 << 5) | (32'd2 << 7), 120, 100, 0);
    for (int k = 0; k < 20; k++)
      phase("R11", EN | 32'h1 | (32'(k % 8) << 7) | (32'(k % 2) << 10) | (32'd1 << 5),
            3 + (k % 5), 100, 0);

    for (int k = 0; k < 600; k++) begin
      logic [31:0] v = $urandom;
      if (($urandom % 10) < 8) v[12] = 1'b1;
      tag_ref = "R7";
      tag_tx  = v[0] ? "R8" : "R9";
      wr(v);
      run(10 + ($urandom % 40), 20 + ($urandom % 81), 20 + ($urandom % 81));
    end

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule